// File: doc/BRIEF.md
# DCC Serial Drop Port

This block watches the byte stream of a received STS-3/STM-1 frame and picks out the data communication channel bytes. These are the three section bytes (D1 to D3) and the nine line bytes (D4 to D12), all carried in the overhead of the first STS-1. During the following frame it sends one group of them out on a serial data line with a gapped clock. A parity byte always comes first.

Two select inputs choose the group. The section group gives 32 bits per frame, which is near 260 kHz. The line group gives 80 bits per frame, which is near 640 kHz. The line group wins if both selects are set. If neither is set, the channel is in full-access mode, which this block does not serve, and the serial port stays idle. A sense input chooses even or odd parity for the leading byte. A marker output flags the first serial bit of each frame.

The serial bit period is a whole number of system clocks. Each half of the serial clock lasts a parameter's number of cycles, and each group has its own parameter.

Top module: `dcc_serial_port`

## Requirements
- R1: A valid byte is captured as a DCC byte only when it is in slot 0 and column 0, 1 or 2. Row 2 holds D1..D3, in column order. Rows 5, 6 and 7 hold D4..D6, D7..D9 and D10..D12, in column order. Bytes at any other row, column or slot are ignored.
- R2: A frame boundary is a valid byte at row 0, column 0, slot 0. The bytes captured during one frame are sent during the next frame. Any DCC byte not received in a frame is sent as 0x00.
- R3: When only the section select is set, the frame carries 4 bytes: the parity byte, then D1, D2 and D3.
- R4: When the line select is set, the frame carries 10 bytes: the parity byte, then D4 through D12. This holds whether or not the section select is also set.
- R5: The parity byte has bits 7..1 at zero. Bit 0 is chosen so that the ones in the sent DCC bytes plus this bit total an even count when par_even is 1, and an odd count when par_even is 0.
- R6: Bytes go out MSB first. Each bit lasts 2*HALF cycles, where HALF is HALF_SEC or HALF_LINE. During a bit, ser_clk is low for the first HALF cycles and high for the rest. ser_data changes only as ser_clk falls. After the last bit, ser_clk stays high.
- R7: The first bit starts, with ser_clk low, in the cycle after the boundary byte is clocked in.
- R8: ser_fp is high for exactly the first serial bit of the frame and low otherwise.
- R9: sel_section, sel_line and par_even are sampled only at a frame boundary. Changes at other times affect nothing until the next boundary.
- R10: When neither select is set, ser_clk stays high and ser_fp stays low for the whole frame.
- R11: A new frame boundary that arrives while a frame is still being sent restarts output from the first parity bit.
- R12: After reset, ser_clk is high, ser_fp and ser_data are low, and the capture store is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Byte qualifier for the frame stream |
| in_byte | input | 8 | Frame byte |
| in_row | input | ROW_W | Row of the byte (0..8) |
| in_col | input | COL_W | Column of the byte within its STS-1 |
| in_slot | input | SLOT_W | STS-1 slot of the byte |
| sel_section | input | 1 | Select the D1..D3 group |
| sel_line | input | 1 | Select the D4..D12 group (takes priority) |
| par_even | input | 1 | 1 selects even parity, 0 selects odd parity |
| ser_data | output | 1 | Serial data, MSB first |
| ser_clk | output | 1 | Gapped serial clock, high when idle |
| ser_fp | output | 1 | Marker for the first bit of the frame |

## Verification
The bench builds the block with HALF_SEC = 3 and HALF_LINE = 1. A section frame then takes 192 cycles and a line frame takes 160, so a 300-cycle frame holds a full transfer and the idle tail after it. Every bit of every frame is checked.

The sweep runs through all four select combinations and both parity senses. It uses arithmetic byte patterns, plus all-ones and all-zeros to test parity at its extremes. It includes frames with missing bytes and decoy bytes at positions next to the DCC positions. One frame is too short for its transfer, so the next frame must restart the output.

// File: rtl/dcc_port_pkg.sv
package dcc_port_pkg;

    typedef enum logic [1:0] {
        CH_FULL    = 2'd0,
        CH_SECTION = 2'd1,
        CH_LINE    = 2'd2
    } ch_mode_e;

    localparam int DCC_BYTES  = 12;
    localparam int SEC_BYTES  = 3;
    localparam int LINE_BYTES = 9;
    localparam int DCC_COLS   = 3;
    localparam int DCC_SLOT   = 0;
    localparam int SEC_ROW    = 2;
    localparam int LINE_ROW0  = 5;
    localparam int LINE_ROWS  = 3;
    localparam int IDX_W      = $clog2(DCC_BYTES);
    localparam int MAX_BITS   = (LINE_BYTES + 1) * 8;
    localparam int BIT_W      = $clog2(MAX_BITS);

    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] idx;
    } dcc_pos_t;

    typedef logic [DCC_BYTES-1:0][7:0] dcc_store_t;

    function automatic dcc_pos_t dcc_locate(input int row, input int col, input int slot);
        dcc_pos_t p;
        p.hit = 1'b0;
        p.idx = '0;
        if (slot == DCC_SLOT && col >= 0 && col < DCC_COLS) begin
            if (row == SEC_ROW) begin
                p.hit = 1'b1;
                p.idx = IDX_W'(col);
            end else if (row >= LINE_ROW0 && row < LINE_ROW0 + LINE_ROWS) begin
                p.hit = 1'b1;
                p.idx = IDX_W'(SEC_BYTES + (row - LINE_ROW0) * DCC_COLS + col);
            end
        end
        return p;
    endfunction

    function automatic ch_mode_e pick_mode(input logic sec, input logic line);
        if (line)     return CH_LINE;
        else if (sec) return CH_SECTION;
        else          return CH_FULL;
    endfunction

    function automatic int group_first(input ch_mode_e m);
        return (m == CH_LINE) ? SEC_BYTES : 0;
    endfunction

    function automatic int group_count(input ch_mode_e m);
        case (m)
            CH_LINE:    return LINE_BYTES;
            CH_SECTION: return SEC_BYTES;
            default:    return 0;
        endcase
    endfunction

    function automatic int frame_bits(input ch_mode_e m);
        return (group_count(m) + 1) * 8;
    endfunction

endpackage

// File: rtl/dcc_capture.sv
module dcc_capture
    import dcc_port_pkg::*;
#(
    parameter int ROW_W  = 4,
    parameter int COL_W  = 7,
    parameter int SLOT_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [7:0]        in_byte,
    input  logic [ROW_W-1:0]  in_row,
    input  logic [COL_W-1:0]  in_col,
    input  logic [SLOT_W-1:0] in_slot,
    output logic              frame_tick,
    output dcc_store_t        fill_q,
    output dcc_store_t        shadow_q
);

    dcc_pos_t pos;

    always_comb begin
        pos        = dcc_locate(int'(in_row), int'(in_col), int'(in_slot));
        frame_tick = in_valid && (in_row == '0) && (in_col == '0) && (in_slot == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fill_q   <= '0;
            shadow_q <= '0;
        end else if (frame_tick) begin
            shadow_q <= fill_q;
            fill_q   <= '0;
        end else if (in_valid && pos.hit) begin
            fill_q[pos.idx] <= in_byte;
        end
    end

endmodule

// File: rtl/dcc_parity.sv
module dcc_parity
    import dcc_port_pkg::*;
(
    input  dcc_store_t bytes_in,
    input  ch_mode_e   mode,
    input  logic       even,
    output logic       par_bit
);

    logic acc;
    int   first;
    int   count;

    always_comb begin
        first = group_first(mode);
        count = group_count(mode);
        acc   = 1'b0;
        for (int i = 0; i < DCC_BYTES; i++) begin
            if (i >= first && i < first + count) begin
                acc = acc ^ (^bytes_in[i]);
            end
        end
        par_bit = even ? acc : ~acc;
    end

endmodule

// File: rtl/dcc_serializer.sv
module dcc_serializer
    import dcc_port_pkg::*;
#(
    parameter int HALF_SEC  = 240,
    parameter int HALF_LINE = 98
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  ch_mode_e         load_mode,
    input  logic             load_par,
    input  dcc_store_t       shadow,
    output logic             ser_data,
    output logic             ser_clk,
    output logic             ser_fp,
    output logic             active_q,
    output ch_mode_e         mode_q,
    output logic [BIT_W-1:0] bit_idx_q
);

    localparam int HALF_MAX = (HALF_SEC > HALF_LINE) ? HALF_SEC : HALF_LINE;
    localparam int CNT_W    = (HALF_MAX > 1) ? $clog2(HALF_MAX) : 1;

    logic             par_q;
    logic             phase_hi_q;
    logic [CNT_W-1:0] half_cnt_q;
    logic [CNT_W-1:0] half_last;
    logic [BIT_W-1:0] bit_last;
    logic [7:0]       cur_byte;
    int               byte_no;
    int               src;

    always_comb begin
        half_last = (mode_q == CH_LINE) ? CNT_W'(HALF_LINE - 1) : CNT_W'(HALF_SEC - 1);
        bit_last  = BIT_W'(frame_bits(mode_q) - 1);
        byte_no   = int'(bit_idx_q) / 8;
        src       = group_first(mode_q) + byte_no - 1;
        if (byte_no == 0) begin
            cur_byte = {7'b0, par_q};
        end else if (src >= 0 && src < DCC_BYTES) begin
            cur_byte = shadow[src];
        end else begin
            cur_byte = 8'h00;
        end
        ser_data = cur_byte[3'd7 - bit_idx_q[2:0]];
        ser_clk  = active_q ? phase_hi_q : 1'b1;
        ser_fp   = active_q && (bit_idx_q == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q   <= 1'b0;
            mode_q     <= CH_FULL;
            par_q      <= 1'b0;
            phase_hi_q <= 1'b0;
            half_cnt_q <= '0;
            bit_idx_q  <= '0;
        end else if (load) begin
            active_q   <= (load_mode != CH_FULL);
            mode_q     <= load_mode;
            par_q      <= load_par;
            phase_hi_q <= 1'b0;
            half_cnt_q <= '0;
            bit_idx_q  <= '0;
        end else if (active_q) begin
            if (half_cnt_q == half_last) begin
                half_cnt_q <= '0;
                phase_hi_q <= !phase_hi_q;
                if (phase_hi_q) begin
                    if (bit_idx_q == bit_last) begin
                        active_q <= 1'b0;
                    end else begin
                        bit_idx_q <= bit_idx_q + 1'b1;
                    end
                end
            end else begin
                half_cnt_q <= half_cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/dcc_serial_port.sv
module dcc_serial_port
    import dcc_port_pkg::*;
#(
    parameter int ROW_W     = 4,
    parameter int COL_W     = 7,
    parameter int SLOT_W    = 2,
    parameter int HALF_SEC  = 240,
    parameter int HALF_LINE = 98
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [7:0]        in_byte,
    input  logic [ROW_W-1:0]  in_row,
    input  logic [COL_W-1:0]  in_col,
    input  logic [SLOT_W-1:0] in_slot,
    input  logic              sel_section,
    input  logic              sel_line,
    input  logic              par_even,
    output logic              ser_data,
    output logic              ser_clk,
    output logic              ser_fp
);

    logic             frame_tick;
    dcc_store_t       fill_q;
    dcc_store_t       shadow_q;
    ch_mode_e         next_mode;
    logic             next_par;
    logic             ser_active;
    ch_mode_e         ser_mode;
    logic [BIT_W-1:0] bit_idx;
    logic             mode_is_line;
    logic             mode_is_full;

    assign next_mode    = pick_mode(sel_section, sel_line);
    assign mode_is_line = (ser_mode == CH_LINE);
    assign mode_is_full = (ser_mode == CH_FULL);

    dcc_capture #(
        .ROW_W  (ROW_W),
        .COL_W  (COL_W),
        .SLOT_W (SLOT_W)
    ) u_cap (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_byte    (in_byte),
        .in_row     (in_row),
        .in_col     (in_col),
        .in_slot    (in_slot),
        .frame_tick (frame_tick),
        .fill_q     (fill_q),
        .shadow_q   (shadow_q)
    );

    dcc_parity u_par (
        .bytes_in (fill_q),
        .mode     (next_mode),
        .even     (par_even),
        .par_bit  (next_par)
    );

    dcc_serializer #(
        .HALF_SEC  (HALF_SEC),
        .HALF_LINE (HALF_LINE)
    ) u_ser (
        .clk       (clk),
        .rst       (rst),
        .load      (frame_tick),
        .load_mode (next_mode),
        .load_par  (next_par),
        .shadow    (shadow_q),
        .ser_data  (ser_data),
        .ser_clk   (ser_clk),
        .ser_fp    (ser_fp),
        .active_q  (ser_active),
        .mode_q    (ser_mode),
        .bit_idx_q (bit_idx)
    );

endmodule

// File: rtl/dcc_serial_port_chk.sv
module dcc_serial_port_chk
    import dcc_port_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             load,
    input logic             ser_active,
    input logic             mode_is_line,
    input logic             mode_is_full,
    input logic [BIT_W-1:0] bit_idx,
    input logic             ser_data,
    input logic             ser_clk,
    input logic             ser_fp
);

    p_data_on_fall_r6: assert property (@(posedge clk) disable iff (rst)
        (!$stable(ser_data) && !$past(load)) |-> $fell(ser_clk));

    p_fp_starts_low_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(ser_fp) |-> !ser_clk);

    p_fp_one_bit_r8: assert property (@(posedge clk) disable iff (rst)
        ($fell(ser_fp) && !$past(load)) |-> $fell(ser_clk));

    p_parity_pad_r5: assert property (@(posedge clk) disable iff (rst)
        (ser_active && bit_idx < 7) |-> !ser_data);

    p_full_idle_r10: assert property (@(posedge clk) disable iff (rst)
        mode_is_full |-> (ser_clk && !ser_fp));

    p_bit_bound_r4: assert property (@(posedge clk) disable iff (rst)
        ser_active |-> (bit_idx < (mode_is_line ? 7'd80 : 7'd32)));

endmodule

bind dcc_serial_port dcc_serial_port_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .load         (frame_tick),
    .ser_active   (ser_active),
    .mode_is_line (mode_is_line),
    .mode_is_full (mode_is_full),
    .bit_idx      (bit_idx),
    .ser_data     (ser_data),
    .ser_clk      (ser_clk),
    .ser_fp       (ser_fp)
);

// File: tb/dcc_serial_port_test.sv
module dcc_serial_port_test;

    localparam int HS = 3;
    localparam int HL = 1;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [7:0] in_byte = '0;
    logic [3:0] in_row = '0;
    logic [6:0] in_col = '0;
    logic [1:0] in_slot = '0;
    logic       sel_section = 1'b0;
    logic       sel_line = 1'b0;
    logic       par_even = 1'b0;
    logic       ser_data;
    logic       ser_clk;
    logic       ser_fp;

    int n_chk = 0;
    int n_fail = 0;
    logic [11:0][7:0] prev = '0;
    logic [11:0]      prev_pres = '1;
    bit aborted = 1'b0;
    bit first_frame = 1'b1;

    always #4 clk = ~clk;

    dcc_serial_port #(
        .HALF_SEC  (HS),
        .HALF_LINE (HL)
    ) uut (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .in_byte     (in_byte),
        .in_row      (in_row),
        .in_col      (in_col),
        .in_slot     (in_slot),
        .sel_section (sel_section),
        .sel_line    (sel_line),
        .par_even    (par_even),
        .ser_data    (ser_data),
        .ser_clk     (ser_clk),
        .ser_fp      (ser_fp)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic put(input int row, input int col, input int slot, input logic [7:0] b);
        in_valid = 1'b1;
        in_row   = 4'(row);
        in_col   = 7'(col);
        in_slot  = 2'(slot);
        in_byte  = b;
    endtask

    task automatic run_frame(input int len, input bit s, input bit l, input bit e,
                             input logic [11:0][7:0] d, input logic [11:0] present);
        int nb    = l ? 80 : (s ? 32 : 0);
        int h     = l ? HL : HS;
        int first = l ? 3 : 0;
        int cnt   = l ? 9 : 3;
        int clk_err = 0;
        logic [9:0][7:0] eb = '0;
        logic acc = 1'b0;
        for (int j = 0; j < cnt; j++) acc ^= ^prev[first + j];
        eb[0] = {7'b0, e ? acc : ~acc};
        for (int j = 0; j < cnt; j++) eb[j + 1] = prev[first + j];
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            if (i >= 1) begin
                int c = i - 1;
                int k = c / (2 * h);
                if (k < nb) begin
                    logic exp_clk = ((c % (2 * h)) >= h);
                    if (ser_clk !== exp_clk) clk_err++;
                    if (c % (2 * h) == 0) begin
                        logic expb = eb[k / 8][7 - (k % 8)];
                        string tg;
                        if (k < 8) tg = "R5";
                        else if (first_frame) tg = "R12";
                        else if (!prev_pres[first + k / 8 - 1]) tg = "R2";
                        else tg = l ? (s ? "R1 R4 R6 both-selects" : "R1 R4 R6") : "R1 R3 R6";
                        chk(ser_data === expb, tg, int'(ser_data), int'(expb));
                        chk(ser_fp === (k == 0), (k == 0 && aborted) ? "R11" : "R8",
                            int'(ser_fp), int'(k == 0));
                        if (c == 0) chk(ser_clk === 1'b0, "R7", int'(ser_clk), 0);
                    end
                end else begin
                    if (ser_clk !== 1'b1 || ser_fp !== 1'b0) clk_err++;
                end
            end
            in_valid = 1'b0;
            if (i == 0) begin
                put(0, 0, 0, 8'hA5);
                sel_section = s;
                sel_line    = l;
                par_even    = e;
            end else if (i >= 1 && i <= 12) begin
                int idx = i - 1;
                if (present[idx]) begin
                    if (idx < 3) put(2, idx, 0, d[idx]);
                    else put(5 + (idx - 3) / 3, (idx - 3) % 3, 0, d[idx]);
                end
            end else if (i == 13) put(2, 0, 1, 8'hFF);
            else if (i == 14) put(5, 3, 0, 8'hFF);
            else if (i == 15) put(4, 0, 0, 8'hFF);
            else if (i == 16) put(0, 0, 1, 8'h3C);
            else if (i == 20) begin
                // R9: selects and sense change away from the boundary
                sel_section = ~s;
                sel_line    = ~l;
                par_even    = ~e;
            end
        end
        chk(clk_err == 0, (nb == 0) ? "R10" : "R6 R9", clk_err, 0);
        for (int j = 0; j < 12; j++) prev[j] = present[j] ? d[j] : 8'h00;
        prev_pres   = present;
        aborted     = (len - 1 < 2 * h * nb);
        first_frame = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [11:0][7:0] d;
        logic [11:0] pres;
        repeat (5) @(negedge clk);
        chk(ser_clk === 1'b1, "R12", int'(ser_clk), 1);
        chk(ser_fp === 1'b0, "R12", int'(ser_fp), 0);
        chk(ser_data === 1'b0, "R12", int'(ser_data), 0);
        rst = 1'b0;
        for (int f = 0; f < 16; f++) begin
            int m = (f + 1) % 4;
            for (int i = 0; i < 12; i++) d[i] = 8'(((i * 37) + (f * 91) + 5) ^ (f * 16));
            if (f == 8) d = '1;
            if (f == 9) d = '0;
            pres = '1;
            if (f == 6) begin
                pres[1] = 1'b0;
                pres[7] = 1'b0;
            end
            run_frame(300, (m == 1 || m == 3), (m >= 2), ((f / 4) % 2) == 1, d, pres);
        end
        for (int i = 0; i < 12; i++) d[i] = 8'(i * 19 + 3);
        run_frame(100, 1'b0, 1'b1, 1'b1, d, '1);   // R11: cut short
        run_frame(300, 1'b0, 1'b1, 1'b0, d, '1);
        run_frame(300, 1'b1, 1'b0, 1'b1, d, '1);
        run_frame(300, 1'b0, 1'b0, 1'b0, d, '1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule